// File: doc/BRIEF.md
# Serial Broadcast Program Loader

This block fills the instruction memories of an 8 × 8 grid of processor tiles from a single serial data line. Each bit that arrives with its valid strobe is shifted into a 20-bit assembly register. When the twentieth bit of a word has been taken in, the block issues one memory write. The write carries the assembled word, the current 8-bit write address and a per-tile write-enable vector. The same word can reach every tile, one row, one column or one tile in a single write. A broadcast group therefore receives a shared program in one pass over the serial line.

The address pointer is preset through a load strobe and steps by one after every completed word. It wraps from 255 to 0. The group is picked at the moment a word completes, from a 2-bit group code and 3-bit row and column selects. Tile number `row*8 + col` maps to bit `row*8 + col` of the enable vector. The memories and the tiles themselves sit outside this block.

Top module: `serial_prog_loader`

## Requirements
- R1: After a synchronous reset, `tile_we` is all zeros and the first completed word is written to address 0.
- R2: Bits enter most significant first: the first accepted bit lands in bit 19 of `wr_word` and the twentieth accepted bit lands in bit 0.
- R3: The write for a word appears on the outputs in the cycle after the clock edge that accepts its twentieth bit. `tile_we` is non-zero for exactly that one cycle.
- R4: A cycle with `ser_valid` low neither shifts nor counts. Gaps of any length between bits leave the assembled word unchanged and issue no write.
- R5: The write address increases by one after each completed word and wraps from 255 to 0.
- R6: A pulse on `addr_load` makes `addr_in` the address of the next completed word. If the pulse falls in the same cycle as a twentieth bit, that word still uses the old address and the loaded value takes priority over the increment.
- R7: Group code 2'b00 sets all 64 bits of `tile_we`.
- R8: Group code 2'b01 sets bits `row_sel*8 + c` for c = 0..7, which is the whole selected row.
- R9: Group code 2'b10 sets bits `r*8 + col_sel` for r = 0..7, which is the whole selected column.
- R10: Group code 2'b11 sets only bit `row_sel*8 + col_sel`.
- R11: Reset discards a partly assembled word. The next 20 accepted bits form a complete new word.
- R12: `wr_word` and `wr_addr` hold their values in cycles without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_valid | input | 1 | Serial bit strobe |
| ser_bit | input | 1 | Serial data bit |
| addr_load | input | 1 | Load `addr_in` into the address pointer |
| addr_in | input | 8 | Preset value for the address pointer |
| grp_mode | input | 2 | Target group: 00 all, 01 row, 10 column, 11 single |
| row_sel | input | 3 | Selected row |
| col_sel | input | 3 | Selected column |
| tile_we | output | 64 | Per-tile write enables, bit row*8+col |
| wr_addr | output | 8 | Instruction memory write address |
| wr_word | output | 20 | Instruction word to write |

## Verification
The bench sends words with an asymmetric bit pattern. A loader that shifts least significant bit first, or that is off by one bit, then writes a visibly wrong word. Words are also sent with idle gaps between bits, which exposes a counter that advances without the strobe. Address runs start at 254 and cross the wrap, and an address load is placed on the same cycle as a final bit. A pointer that does not wrap, or that lets the increment beat the load, writes to the wrong address. Row, column and single-tile groups use off-centre selects, so swapped row and column indices light the wrong enable bits. A reset in the middle of a word checks that stale bits do not leak into the next word.

// File: rtl/serial_prog_loader.sv
module serial_prog_loader #(
  parameter int WORD_W = 20,
  parameter int ADDR_W = 8,
  parameter int ROWS   = 8,
  parameter int COLS   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ser_valid,
  input  logic                   ser_bit,
  input  logic                   addr_load,
  input  logic [ADDR_W-1:0]      addr_in,
  input  logic [1:0]             grp_mode,
  input  logic [$clog2(ROWS)-1:0] row_sel,
  input  logic [$clog2(COLS)-1:0] col_sel,
  output logic [ROWS*COLS-1:0]   tile_we,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [WORD_W-1:0]      wr_word
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int TILES = ROWS * COLS;

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr;
  logic [TILES-1:0]  grp_mask;
  logic              done;

  assign done = ser_valid && (cnt == CNT_W'(WORD_W - 1));

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic hit_r, hit_c;
      assign hit_r = (row_sel == ROW_W'(r));
      assign hit_c = (col_sel == COL_W'(c));
      always_comb begin
        unique case (grp_mode)
          2'b00:   grp_mask[r*COLS+c] = 1'b1;
          2'b01:   grp_mask[r*COLS+c] = hit_r;
          2'b10:   grp_mask[r*COLS+c] = hit_c;
          default: grp_mask[r*COLS+c] = hit_r && hit_c;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      shreg   <= '0;
      addr    <= '0;
      tile_we <= '0;
      wr_addr <= '0;
      wr_word <= '0;
    end else begin
      tile_we <= '0;
      if (ser_valid) begin
        shreg <= {shreg[WORD_W-2:0], ser_bit};
        cnt   <= done ? '0 : cnt + 1'b1;
      end
      if (done) begin
        tile_we <= grp_mask;
        wr_addr <= addr;
        wr_word <= {shreg[WORD_W-2:0], ser_bit};
      end
      if (addr_load)  addr <= addr_in;
      else if (done)  addr <= addr + 1'b1;
    end
  end

  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (tile_we != '0) |=> (tile_we == '0));

  // R7 R8 R9 R10
  we_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (tile_we != '0) |-> ($countones(tile_we) == 1 || $countones(tile_we) == COLS
                         || $countones(tile_we) == ROWS || $countones(tile_we) == TILES));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ser_valid && !addr_load) |=> ($stable(shreg) && $stable(addr) && tile_we == '0));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !addr_load) |=> (addr == $past(addr) + 1'b1 && wr_addr == $past(addr)));

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!done) |=> ($stable(wr_word) && $stable(wr_addr)));
endmodule

// File: tb/tb_serial_prog_loader.sv
module tb_serial_prog_loader;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        ser_valid = 0, ser_bit = 0, addr_load = 0;
  logic [7:0]  addr_in = 0;
  logic [1:0]  grp_mode = 0;
  logic [2:0]  row_sel = 0, col_sel = 0;
  logic [63:0] tile_we;
  logic [7:0]  wr_addr;
  logic [19:0] wr_word;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_prog_loader dut (
    .clk(clk), .rst(rst), .ser_valid(ser_valid), .ser_bit(ser_bit),
    .addr_load(addr_load), .addr_in(addr_in), .grp_mode(grp_mode),
    .row_sel(row_sel), .col_sel(col_sel),
    .tile_we(tile_we), .wr_addr(wr_addr), .wr_word(wr_word));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_mask(logic [1:0] m, int rs, int cs);
    logic [63:0] v = '0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        if (m == 2'b00 || (m == 2'b01 && r == rs) || (m == 2'b10 && c == cs) ||
            (m == 2'b11 && r == rs && c == cs))
          v[r*8+c] = 1'b1;
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1; ser_valid = 0; addr_load = 0;
    @(negedge clk); rst = 0;
  endtask

  // Sends one word MSB first; returns at the negedge after the write edge.
  task automatic send_word(logic [19:0] w, int gap);
    for (int i = 19; i >= 0; i--) begin
      @(negedge clk); ser_valid = 1; ser_bit = w[i];
      if (gap > 0 && i > 0) begin
        @(negedge clk); ser_valid = 0; ser_bit = ~w[i];
        repeat (gap - 1) @(negedge clk);
        if (tile_we !== '0) chk("R4 no write in gap", tile_we, 64'h0);
      end
    end
    @(negedge clk); ser_valid = 0;
  endtask

  task automatic expect_write(string req, logic [19:0] w, logic [7:0] a, logic [63:0] m);
    chk({req, " word"}, {44'h0, wr_word}, {44'h0, w});
    chk({req, " addr"}, {56'h0, wr_addr}, {56'h0, a});
    chk({req, " we"}, tile_we, m);
    @(negedge clk);
    chk("R3 we one cycle", tile_we, 64'h0);
  endtask

  task automatic load_addr(logic [7:0] a);
    @(negedge clk); addr_load = 1; addr_in = a;
    @(negedge clk); addr_load = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 we after reset", tile_we, 64'h0);
    chk("R1 addr after reset", {56'h0, wr_addr}, 64'h0);
  endtask

  task automatic t_all();
    grp_mode = 2'b00;
    send_word(20'hA35C1, 0);
    expect_write("R1 R2 R7 all", 20'hA35C1, 8'd0, exp_mask(2'b00, 0, 0));
  endtask

  task automatic t_row();
    grp_mode = 2'b01; row_sel = 3'd5; col_sel = 3'd1;
    send_word(20'h80001, 0);
    expect_write("R5 R8 row", 20'h80001, 8'd1, exp_mask(2'b01, 5, 1));
  endtask

  task automatic t_col();
    grp_mode = 2'b10; row_sel = 3'd6; col_sel = 3'd2;
    send_word(20'h0F0F3, 0);
    expect_write("R9 column", 20'h0F0F3, 8'd2, exp_mask(2'b10, 6, 2));
  endtask

  task automatic t_single();
    grp_mode = 2'b11; row_sel = 3'd7; col_sel = 3'd3;
    send_word(20'h12345, 0);
    expect_write("R10 single", 20'h12345, 8'd3, 64'h1 << 59);
  endtask

  task automatic t_gaps();
    grp_mode = 2'b11; row_sel = 3'd0; col_sel = 3'd6;
    send_word(20'hC0DE9, 3);
    expect_write("R4 gaps", 20'hC0DE9, 8'd4, 64'h1 << 6);
  endtask

  task automatic t_hold();
    repeat (5) @(negedge clk);
    chk("R12 word held", {44'h0, wr_word}, {44'h0, 20'hC0DE9});
    chk("R12 addr held", {56'h0, wr_addr}, 64'd4);
    chk("R12 no write", tile_we, 64'h0);
  endtask

  task automatic t_wrap();
    grp_mode = 2'b00;
    load_addr(8'd254);
    send_word(20'h11111, 0); expect_write("R6 load", 20'h11111, 8'd254, {64{1'b1}});
    send_word(20'h22222, 0); expect_write("R5 top", 20'h22222, 8'd255, {64{1'b1}});
    send_word(20'h33333, 0); expect_write("R5 wrap", 20'h33333, 8'd0, {64{1'b1}});
  endtask

  task automatic t_priority();
    logic [19:0] w = 20'h5A5A6;
    grp_mode = 2'b01; row_sel = 3'd2;
    for (int i = 19; i >= 0; i--) begin
      @(negedge clk); ser_valid = 1; ser_bit = w[i];
      if (i == 0) begin addr_load = 1; addr_in = 8'd77; end
    end
    @(negedge clk); ser_valid = 0; addr_load = 0;
    expect_write("R6 old addr on collision", w, 8'd1, exp_mask(2'b01, 2, 0));
    send_word(20'h6B6B7, 0);
    expect_write("R6 load beats increment", 20'h6B6B7, 8'd77, exp_mask(2'b01, 2, 0));
  endtask

  task automatic t_partial();
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); ser_valid = 1; ser_bit = 1'b1;
    end
    do_reset();
    grp_mode = 2'b00;
    send_word(20'h00F01, 0);
    expect_write("R11 partial discarded", 20'h00F01, 8'd0, {64{1'b1}});
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_all();
    t_row();
    t_col();
    t_single();
    t_gaps();
    t_hold();
    t_wrap();
    t_priority();
    t_partial();
    finish_run();
  end
endmodule